// File: doc/BRIEF.md
# Drum Printer Line Control

This block runs one print line on a drum printer whose columns each have a storage latch. A command selects either a print line or a paper move on its own. For a print line the block waits for each drum position code. On every code it reads the line from memory, two characters per read, and shifts one bit per column into the printer latches. The bit tells a column to fire when its character comes under the hammer. The printer echoes every bit back. The block compares the echo with the bit it sent and returns a per-column comparison bit.

A column fires at most once per line. Once a scan leaves no nonblank column waiting, the block releases the paper at once, without waiting for the rest of the drum. The move applies a carriage channel skip, which takes precedence, or else a single or double space. A separate monitor counts the position codes seen between revolution marks and reports a drum exception when the count is not 64.

Top module: `lp_line_ctrl`

## Requirements
- R1: Each memory read returns two characters: the high byte belongs to the even column and the low byte to the odd column. Every completed read (`mem_rd_o` and `mem_ack_i` both high) is followed, in the next two cycles, by exactly two column strobes.
- R2: Two cycles after each column strobe, `cmp_stb_o` pulses. `cmp_bit_o` is 1 if the echo matched the bit sent and 0 if it did not. A mismatch sets `bit_err_o`, which stays set until the next accepted command (op 10 or 11).
- R3: Each accepted position code starts one scan of strobes over columns 0 upward. A column's bit is 1 only if that column is still waiting and bits [5:0] of its character equal the position code. No strobe occurs outside a scan.
- R4: A scan covers 132 columns when `cmd_wide_i` was 1 at acceptance and 120 columns otherwise. Characters beyond that count are never printed.
- R5: The character 0x80 ends the line. That column and every later column give 0 in every scan.
- R6: The character 0x40 is blank and never gives a 1 bit.
- R7: Over one line, each nonblank column within the line gets exactly one 1 bit, and no other column gets any.
- R8: In the cycle after the last strobe of the first scan that leaves no column waiting, `done_o` pulses once, together with any paper move. At most 64 scans are run per line.
- R9: A skip field of 1 to 11 gives `motion_skip_o`=1 with `motion_arg_o` equal to the channel, and it overrides spacing. Otherwise space 1 or 2 gives `motion_skip_o`=0 with the line count in `motion_arg_o`. Other values give no move, but `done_o` still pulses. Op 11 moves paper in the cycle after acceptance with no scan. Ops 00 and 01 are ignored.
- R10: A position strobe with `index_i` high marks a revolution start. If the number of strobes since the previous mark is not 64, `drum_err_o` sets in the next cycle and stays set until the next accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_vld_i | input | 1 | Command present |
| cmd_op_i | input | 2 | 10 print line, 11 paper move only |
| cmd_space_i | input | 2 | Lines to advance (0, 1, 2) |
| cmd_skip_i | input | 4 | Carriage channel 1..11, 0 for none |
| cmd_wide_i | input | 1 | 1 selects 132 columns, 0 selects 120 |
| cmd_rdy_o | output | 1 | Block idle, command is taken |
| mem_rd_o | output | 1 | Character pair read request |
| mem_addr_o | output | 7 | Pair index (column / 2) |
| mem_ack_i | input | 1 | Read data valid this cycle |
| mem_data_i | input | 16 | Character pair, even column in high byte |
| pos_vld_i | input | 1 | Drum position code strobe |
| pos_code_i | input | 6 | Drum position code |
| index_i | input | 1 | Revolution start, with a position strobe |
| col_stb_o | output | 1 | Column bit valid |
| col_bit_o | output | 1 | Column bit to printer latch |
| col_echo_i | input | 1 | Echo of the bit sent one cycle earlier |
| cmp_stb_o | output | 1 | Comparison bit valid |
| cmp_bit_o | output | 1 | 1 match, 0 mismatch |
| motion_stb_o | output | 1 | Paper move request |
| motion_skip_o | output | 1 | 1 channel skip, 0 spacing |
| motion_arg_o | output | 4 | Channel or line count |
| done_o | output | 1 | Line or move finished |
| bit_err_o | output | 1 | Echo mismatch seen |
| drum_err_o | output | 1 | Wrong position count in a revolution |

## Verification
Each column bit is judged in the cycle of its strobe. Its comparison bit is due two cycles later, and the move and `done_o` are due in the cycle after the final strobe, or one cycle after an op 11 is accepted. The drum status is due one cycle after each revolution mark. The bench drives at the falling edge and samples there, in exactly those cycles. Its printer model echoes on the rising edge, so echo timing is fixed by the clock. Its behavioural model of waiting columns predicts every scan's bit vector and the scan on which the paper must be released.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  localparam int unsigned CHAR_W   = 8;
  localparam int unsigned POS_W    = 6;
  localparam logic [7:0]  BLANK_CH = 8'h40;
  localparam logic [7:0]  DELIM_CH = 8'h80;
  localparam logic [1:0]  OP_WRITE = 2'b10;
  localparam logic [1:0]  OP_SKIP  = 2'b11;
  localparam logic [3:0]  SKIP_MAX = 4'd11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAITP, ST_FETCH, ST_SHIFT, ST_MOTION
  } state_t;
endpackage

// File: rtl/lpc_pair_buf.sv
module lpc_pair_buf import lpc_pkg::*; (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [2*CHAR_W-1:0] data_i,
  input  logic                sel_i,
  output logic [CHAR_W-1:0]   char_o
);
  logic [2*CHAR_W-1:0] buf_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     buf_q <= '0;
    else if (load_i) buf_q <= data_i;

  // even column sits in the upper byte
  assign char_o = sel_i ? buf_q[CHAR_W-1:0] : buf_q[2*CHAR_W-1:CHAR_W];
endmodule

// File: rtl/lpc_echo_chk.sv
module lpc_echo_chk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic bit_i,
  input  logic echo_i,
  input  logic clr_i,
  output logic cmp_stb_o,
  output logic cmp_bit_o,
  output logic err_o
);
  logic stb_q, bit_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      stb_q <= 1'b0; bit_q <= 1'b0;
      cmp_stb_o <= 1'b0; cmp_bit_o <= 1'b0; err_o <= 1'b0;
    end else begin
      stb_q     <= stb_i;
      bit_q     <= bit_i;
      cmp_stb_o <= stb_q;
      cmp_bit_o <= stb_q & (echo_i == bit_q);
      if (clr_i) err_o <= 1'b0;
      if (stb_q && (echo_i != bit_q)) err_o <= 1'b1;
    end
endmodule

// File: rtl/lpc_drum_mon.sv
module lpc_drum_mon #(
  parameter int unsigned NPOS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pos_vld_i,
  input  logic index_i,
  input  logic clr_i,
  output logic err_o
);
  localparam int unsigned CW = $clog2(NPOS + 2);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q <= '0; seen_q <= 1'b0; err_o <= 1'b0;
    end else begin
      if (clr_i) err_o <= 1'b0;
      if (pos_vld_i && index_i) begin
        if (seen_q && cnt_q != CW'(NPOS)) err_o <= 1'b1;
        cnt_q  <= CW'(1);
        seen_q <= 1'b1;
      end else if (pos_vld_i && cnt_q != CMAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
endmodule

// File: rtl/lp_line_ctrl.sv
module lp_line_ctrl import lpc_pkg::*; #(
  parameter int unsigned MAX_COLS    = 132,
  parameter int unsigned NARROW_COLS = 120,
  parameter int unsigned NPOS        = 64
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             cmd_vld_i,
  input  logic [1:0]                       cmd_op_i,
  input  logic [1:0]                       cmd_space_i,
  input  logic [3:0]                       cmd_skip_i,
  input  logic                             cmd_wide_i,
  output logic                             cmd_rdy_o,
  output logic                             mem_rd_o,
  output logic [$clog2(MAX_COLS/2)-1:0]    mem_addr_o,
  input  logic                             mem_ack_i,
  input  logic [15:0]                      mem_data_i,
  input  logic                             pos_vld_i,
  input  logic [5:0]                       pos_code_i,
  input  logic                             index_i,
  output logic                             col_stb_o,
  output logic                             col_bit_o,
  input  logic                             col_echo_i,
  output logic                             cmp_stb_o,
  output logic                             cmp_bit_o,
  output logic                             motion_stb_o,
  output logic                             motion_skip_o,
  output logic [3:0]                       motion_arg_o,
  output logic                             done_o,
  output logic                             bit_err_o,
  output logic                             drum_err_o
);
  localparam int unsigned COL_W = $clog2(MAX_COLS);
  localparam int unsigned GC_W  = $clog2(NPOS + 1);

  state_t            st_q;
  logic [1:0]        space_q;
  logic [3:0]        skip_q;
  logic              wide_q, first_q, half_q, ended_q, left_q;
  logic [POS_W-1:0]  code_q;
  logic [COL_W-1:0]  col_q, last_col;
  logic [GC_W-1:0]   gcnt_q;
  logic [MAX_COLS-1:0] pend_q;
  logic [CHAR_W-1:0] ch;
  logic cmd_acc, ended_now, nonblank, eff, hit, left, skip_ok, space_ok;

  assign cmd_acc  = (st_q == ST_IDLE) && cmd_vld_i && cmd_op_i[1];
  assign last_col = wide_q ? COL_W'(MAX_COLS - 1) : COL_W'(NARROW_COLS - 1);

  lpc_pair_buf i_pair (
    .clk_i, .rst_ni,
    .load_i (st_q == ST_FETCH && mem_ack_i),
    .data_i (mem_data_i),
    .sel_i  (half_q),
    .char_o (ch)
  );

  // column decision: pending on first scan comes from the character itself
  assign ended_now = ended_q | (ch == DELIM_CH);
  assign nonblank  = !ended_now && (ch != BLANK_CH);
  assign eff       = first_q ? nonblank : pend_q[col_q];
  assign hit       = eff && (ch[POS_W-1:0] == code_q);
  assign left      = eff && !hit;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q <= ST_IDLE; space_q <= '0; skip_q <= '0; wide_q <= 1'b0;
      first_q <= 1'b0; half_q <= 1'b0; ended_q <= 1'b0; left_q <= 1'b0;
      code_q <= '0; col_q <= '0; gcnt_q <= '0; pend_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (cmd_acc) begin
          space_q <= cmd_space_i;
          skip_q  <= cmd_skip_i;
          wide_q  <= cmd_wide_i;
          first_q <= 1'b1;
          gcnt_q  <= GC_W'(NPOS);
          st_q    <= (cmd_op_i == OP_WRITE) ? ST_WAITP : ST_MOTION;
        end
        ST_WAITP: if (pos_vld_i) begin
          code_q  <= pos_code_i;
          col_q   <= '0;
          half_q  <= 1'b0;
          ended_q <= 1'b0;
          left_q  <= 1'b0;
          st_q    <= ST_FETCH;
        end
        ST_FETCH: if (mem_ack_i) st_q <= ST_SHIFT;
        ST_SHIFT: begin
          pend_q[col_q] <= left;
          left_q  <= left_q | left;
          ended_q <= ended_now;
          col_q   <= col_q + 1'b1;
          half_q  <= ~half_q;
          if (col_q == last_col) begin
            first_q <= 1'b0;
            gcnt_q  <= gcnt_q - 1'b1;
            st_q    <= (!(left_q || left) || gcnt_q == GC_W'(1)) ? ST_MOTION : ST_WAITP;
          end else if (half_q) begin
            st_q <= ST_FETCH;
          end
        end
        ST_MOTION: st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end

  assign cmd_rdy_o  = (st_q == ST_IDLE);
  assign mem_rd_o   = (st_q == ST_FETCH);
  assign mem_addr_o = col_q[COL_W-1:1];
  assign col_stb_o  = (st_q == ST_SHIFT);
  assign col_bit_o  = (st_q == ST_SHIFT) && hit;

  assign skip_ok       = (skip_q != 4'd0) && (skip_q <= SKIP_MAX);
  assign space_ok      = (space_q == 2'd1) || (space_q == 2'd2);
  assign done_o        = (st_q == ST_MOTION);
  assign motion_stb_o  = done_o && (skip_ok || space_ok);
  assign motion_skip_o = done_o && skip_ok;
  assign motion_arg_o  = !done_o ? 4'd0 : skip_ok ? skip_q : space_ok ? {2'b00, space_q} : 4'd0;

  lpc_echo_chk i_echo (
    .clk_i, .rst_ni,
    .stb_i     (col_stb_o),
    .bit_i     (col_bit_o),
    .echo_i    (col_echo_i),
    .clr_i     (cmd_acc),
    .cmp_stb_o (cmp_stb_o),
    .cmp_bit_o (cmp_bit_o),
    .err_o     (bit_err_o)
  );

  lpc_drum_mon #(.NPOS(NPOS)) i_drum (
    .clk_i, .rst_ni,
    .pos_vld_i (pos_vld_i),
    .index_i   (index_i),
    .clr_i     (cmd_acc),
    .err_o     (drum_err_o)
  );
endmodule

// File: rtl/lp_line_ctrl_chk.sv
module lp_line_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_rdy_o,
  input logic       mem_rd_o,
  input logic       mem_ack_i,
  input logic       col_stb_o,
  input logic       cmp_stb_o,
  input logic       cmp_bit_o,
  input logic       bit_err_o,
  input logic       motion_stb_o,
  input logic       motion_skip_o,
  input logic [3:0] motion_arg_o,
  input logic       done_o
);
  p_pair_two_strobes_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && mem_ack_i) |=> (col_stb_o && !mem_rd_o) ##1 col_stb_o);

  p_cmp_lag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_stb_o |-> $past(col_stb_o, 2));

  p_mismatch_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_stb_o && !cmp_bit_o) |-> bit_err_o);

  p_motion_after_print_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    motion_stb_o |-> (done_o && !col_stb_o && !mem_rd_o));

  p_skip_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (motion_stb_o && motion_skip_o) |-> (motion_arg_o >= 4'd1 && motion_arg_o <= 4'd11));

  p_space_arg_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (motion_stb_o && !motion_skip_o) |-> (motion_arg_o == 4'd1 || motion_arg_o == 4'd2));

  p_idle_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rdy_o |-> (!col_stb_o && !mem_rd_o));
endmodule

bind lp_line_ctrl lp_line_ctrl_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_rdy_o(cmd_rdy_o), .mem_rd_o(mem_rd_o),
  .mem_ack_i(mem_ack_i), .col_stb_o(col_stb_o), .cmp_stb_o(cmp_stb_o),
  .cmp_bit_o(cmp_bit_o), .bit_err_o(bit_err_o), .motion_stb_o(motion_stb_o),
  .motion_skip_o(motion_skip_o), .motion_arg_o(motion_arg_o), .done_o(done_o)
);

// File: tb/test_lp_line_ctrl.sv
`timescale 1ns/1ps
module test_lp_line_ctrl;
  localparam int MAXC = 132;
  localparam int PER  = 208;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic cmd_vld_i, cmd_wide_i, cmd_rdy_o;
  logic [1:0] cmd_op_i, cmd_space_i;
  logic [3:0] cmd_skip_i;
  logic mem_rd_o, mem_ack_i;
  logic [6:0] mem_addr_o;
  logic [15:0] mem_data_i;
  logic pos_vld_i, index_i;
  logic [5:0] pos_code_i;
  logic col_stb_o, col_bit_o, col_echo_i;
  logic cmp_stb_o, cmp_bit_o;
  logic motion_stb_o, motion_skip_o, done_o, bit_err_o, drum_err_o;
  logic [3:0] motion_arg_o;

  logic [7:0] chars [0:MAXC-1];

  always #2.5 clk_i = ~clk_i;

  lp_line_ctrl i_lp_line_ctrl (.*);

  assign mem_ack_i  = mem_rd_o;
  assign mem_data_i = {chars[2*int'(mem_addr_o)], chars[2*int'(mem_addr_o)+1]};

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- printer echo model ----------------
  int inj_req = 0, inj_done = 0;
  logic inj_d1 = 1'b0, inj_d2 = 1'b0;
  always @(posedge clk_i) begin
    if (col_stb_o && col_bit_o && (inj_req != inj_done)) begin
      col_echo_i <= ~col_bit_o;
      inj_done   <= inj_done + 1;
      inj_d1     <= 1'b1;
    end else begin
      col_echo_i <= col_bit_o;
      inj_d1     <= 1'b0;
    end
    inj_d2 <= inj_d1;
  end

  // ---------------- line model ----------------
  bit pend_m [0:MAXC-1];
  bit nb_m   [0:MAXC-1];
  bit exp_b  [0:MAXC-1];
  int printed[0:MAXC-1];
  int ncol_m, gleft_m, cidx, bad_col, bad_act, bad_exp;
  bit first_m, lactive = 0, final_scan, armed = 0, want_motion = 0, line_done;
  bit exp_mstb, exp_mskip; int exp_marg;
  int n_cmp, n_colstb, cmp_bad, done_cnt = 0;

  task automatic model_scan(input int code);
    bit ended = 0, anyleft = 0;
    for (int c = 0; c < MAXC; c++) begin
      bit nb, eff, m;
      exp_b[c] = 0;
      if (c < ncol_m) begin
        if (chars[c] == 8'h80) ended = 1;
        nb  = !ended && chars[c] != 8'h40;
        eff = first_m ? nb : pend_m[c];
        m   = int'(chars[c][5:0]) == code;
        exp_b[c]  = eff && m;
        pend_m[c] = eff && !m;
        anyleft   = anyleft | pend_m[c];
      end
    end
    first_m = 0;
    gleft_m--;
    if (!anyleft || gleft_m == 0) begin lactive = 0; final_scan = 1; end
    cidx = 0; bad_col = -1; armed = 1;
  endtask

  // ---------------- drum model ----------------
  int since_pulse = 0, code_g = 63, rev_cnt = 0, idx_cnt = 0;
  bit seen_g = 0, chk_idx = 0, drop_req = 0, exp_derr = 0;

  initial begin
    pos_vld_i = 0; index_i = 0; pos_code_i = '0;
    wait (rst_ni === 1'b1);
    forever begin
      @(negedge clk_i);
      if (pos_vld_i) begin
        pos_vld_i = 0; index_i = 0;
        if (chk_idx) begin
          chk(drum_err_o == exp_derr, "R10 drum status after mark", drum_err_o, exp_derr);
          chk_idx = 0;
        end
      end
      since_pulse++;
      if (since_pulse >= PER) begin
        since_pulse = 0;
        code_g = (code_g + 1) % 64;
        if (drop_req && code_g == 20) drop_req = 0;
        else begin
          pos_vld_i = 1; pos_code_i = code_g[5:0]; index_i = (code_g == 0);
          if (index_i) begin
            if (seen_g && rev_cnt != 64) exp_derr = 1;
            rev_cnt = 1; seen_g = 1; chk_idx = 1; idx_cnt++;
          end else rev_cnt++;
          if (lactive) model_scan(code_g);
        end
      end
    end
  end

  // ---------------- output monitor ----------------
  initial forever begin
    @(negedge clk_i);
    if (rst_ni) begin
      if (done_o) done_cnt++;
      if (cmp_stb_o) begin
        n_cmp++;
        if (cmp_bit_o != !inj_d2) cmp_bad++;
        if (inj_d2) chk(cmp_bit_o == 1'b0, "R2 injected mismatch", cmp_bit_o, 0);
      end
      if (col_stb_o) begin
        n_colstb++;
        if (!armed) chk(0, "R3 strobe outside scan", 1, 0);
        else begin
          if (col_bit_o && cidx < MAXC) printed[cidx]++;
          if (bad_col < 0 && col_bit_o != exp_b[cidx]) begin
            bad_col = cidx; bad_act = col_bit_o; bad_exp = exp_b[cidx];
          end
          cidx++;
          if (cidx == ncol_m) begin
            chk(bad_col < 0, $sformatf("R3 column bits, col %0d", bad_col), bad_act, bad_exp);
            armed = 0;
            if (final_scan) begin final_scan = 0; want_motion = 1; end
          end
        end
      end else if (want_motion) begin
        bit pr_ok = 1;
        want_motion = 0;
        chk(done_o == 1'b1, "R8 done after releasing scan", done_o, 1);
        chk(motion_stb_o == exp_mstb, "R9 move strobe", motion_stb_o, exp_mstb);
        if (exp_mstb) begin
          chk(motion_skip_o == exp_mskip, "R9 skip select", motion_skip_o, exp_mskip);
          chk(int'(motion_arg_o) == exp_marg, "R9 move argument", motion_arg_o, exp_marg);
        end
        for (int c = 0; c < MAXC; c++)
          if (printed[c] != (nb_m[c] ? 1 : 0)) pr_ok = 0;
        chk(pr_ok, "R7 one hit per nonblank column (R4 R5 R6 bounds)", pr_ok, 1);
        line_done = 1;
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic set_motion(input [1:0] sp, input [3:0] sk);
    if (sk >= 1 && sk <= 11) begin exp_mstb = 1; exp_mskip = 1; exp_marg = sk; end
    else if (sp == 1 || sp == 2) begin exp_mstb = 1; exp_mskip = 0; exp_marg = sp; end
    else begin exp_mstb = 0; exp_mskip = 0; exp_marg = 0; end
  endtask

  task automatic do_line(input bit wide, input [1:0] sp, input [3:0] sk, input string tag);
    bit ended = 0;
    int d0, t;
    while (since_pulse != 5) @(negedge clk_i);
    ncol_m = wide ? 132 : 120;
    first_m = 1; gleft_m = 64; final_scan = 0; line_done = 0;
    for (int c = 0; c < MAXC; c++) begin
      pend_m[c] = 0; printed[c] = 0;
      if (c < ncol_m && chars[c] == 8'h80) ended = 1;
      nb_m[c] = (c < ncol_m) && !ended && chars[c] != 8'h40;
    end
    set_motion(sp, sk);
    n_cmp = 0; n_colstb = 0; cmp_bad = 0; d0 = done_cnt;
    cmd_vld_i = 1; cmd_op_i = 2'b10; cmd_space_i = sp; cmd_skip_i = sk; cmd_wide_i = wide;
    exp_derr = 0;
    @(negedge clk_i);
    cmd_vld_i = 0; lactive = 1;
    chk(bit_err_o == 0 && drum_err_o == 0, {"R2 R10 status cleared on accept ", tag},
        {bit_err_o, drum_err_o}, 0);
    t = 0;
    while (!line_done && t < 20000) begin @(negedge clk_i); t++; end
    chk(line_done, {"R8 line finished ", tag}, line_done, 1);
    repeat (3) @(negedge clk_i);
    chk(done_cnt == d0 + 1, {"R8 single done ", tag}, done_cnt - d0, 1);
    chk(n_cmp == n_colstb && cmp_bad == 0, {"R2 comparison stream ", tag}, cmp_bad, 0);
  endtask

  task automatic do_move(input [1:0] op, input [1:0] sp, input [3:0] sk);
    int d0 = done_cnt;
    while (since_pulse != 5) @(negedge clk_i);
    cmd_vld_i = 1; cmd_op_i = op; cmd_space_i = sp; cmd_skip_i = sk; cmd_wide_i = 0;
    if (op[1]) exp_derr = 0;
    @(negedge clk_i);
    cmd_vld_i = 0;
    if (op == 2'b11) begin
      set_motion(sp, sk);
      chk(done_o == 1, "R9 move-only done next cycle", done_o, 1);
      chk(motion_stb_o == exp_mstb && motion_skip_o == exp_mskip && int'(motion_arg_o) == exp_marg,
          "R9 move-only fields", motion_arg_o, exp_marg);
    end else begin
      chk(cmd_rdy_o == 1, "R9 ignored opcode leaves block idle", cmd_rdy_o, 1);
      repeat (20) @(negedge clk_i);
      chk(done_cnt == d0, "R9 ignored opcode gives no done", done_cnt - d0, 0);
    end
  endtask

  // ---------------- main sequence ----------------
  initial begin
    rst_ni = 0; cmd_vld_i = 0; cmd_op_i = 0; cmd_space_i = 0; cmd_skip_i = 0; cmd_wide_i = 0;
    for (int c = 0; c < MAXC; c++) chars[c] = 8'h40;
    repeat (5) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(cmd_rdy_o == 1 && col_stb_o == 0 && done_o == 0, "R3 reset idle", cmd_rdy_o, 1);
    chk(bit_err_o == 0 && drum_err_o == 0 && motion_stb_o == 0, "R10 reset status",
        {bit_err_o, drum_err_o}, 0);

    // narrow line, few characters, one beyond column 120
    chars[0] = 8'hC1; chars[1] = 8'hC5; chars[3] = 8'hC1; chars[7] = 8'h03; chars[125] = 8'hC7;
    do_line(1'b0, 2'd1, 4'd0, "narrow");

    // wide line with delimiter; skip overrides space
    for (int c = 0; c < MAXC; c++) chars[c] = (c < 10) ? 8'(8'hC0 + 3 * c) : 8'hC2;
    chars[10] = 8'h80;
    do_line(1'b1, 2'd2, 4'd5, "delimited");

    // full wide line, one echo corrupted, no move
    for (int c = 0; c < MAXC; c++) chars[c] = 8'hC0 | 8'(c % 64);
    inj_req++;
    do_line(1'b1, 2'd0, 4'd0, "full");
    chk(bit_err_o == 1, "R2 mismatch flag held", bit_err_o, 1);

    do_move(2'b11, 2'd0, 4'd11);
    chk(bit_err_o == 0, "R2 flag cleared by command", bit_err_o, 0);
    do_move(2'b11, 2'd2, 4'd13);
    do_move(2'b01, 2'd1, 4'd0);

    // drum exception: one position code missing
    begin
      int i0;
      drop_req = 1;
      while (drop_req) @(negedge clk_i);
      i0 = idx_cnt;
      while (idx_cnt == i0) @(negedge clk_i);
      repeat (4) @(negedge clk_i);
      chk(drum_err_o == 1, "R10 short revolution flagged", drum_err_o, 1);
      do_move(2'b11, 2'd1, 4'd0);
      chk(drum_err_o == 0, "R10 flag cleared by command", drum_err_o, 0);
    end

    repeat (10) @(negedge clk_i);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule